// File: doc/BRIEF.md
# Stepped Reference Ramp Sequencer

This block drives the digital reference code of one buck converter channel. When the supply is healthy, the global switch is on and the channel enable goes high, it starts switching and walks a 6-bit reference code from 0 up to full scale. Each code is held for a fixed number of oscillator cycles. Once the top code has been held for its full dwell, it signals power good.

Dropping the channel enable starts an equally slow walk back down to code 0, after which switching stops. A change of enable in the middle of a ramp turns the walk around from the code it has reached. Loss of the supply-healthy flag or of the global switch stops switching and clears power good in the same cycle, and the code returns to 0 at the next clock edge.

Top module: `reframp_seq`

## Requirements
- R1: After reset, `ref_code` is 0 and `sw_en`, `ramping` and `pwr_good` are all 0.
- R2: With `supply_ok` and `global_on` high, the first clock edge that samples `chan_en` high makes `sw_en` 1. `ref_code` stays at 0 at that edge.
- R3: During a ramp, `ref_code` changes by exactly one step at a time. Each code is held for `DWELL` (64) clock edges, so code k appears 64·k edges after the starting edge.
- R4: Counting from the starting edge, `pwr_good` rises on the 4096th later edge. At that point `ref_code` is 63 and `chan_en` is still high. `pwr_good` is never 1 unless `ref_code` is 63.
- R5: Driving `chan_en` low drops `pwr_good` in the same cycle, before any clock edge. The code then falls by one step every 64 edges.
- R6: After a full ramp-down from 63, `ref_code` reaches 0 after 63·64 edges. `sw_en` falls 4096 edges after the edge that first sampled `chan_en` low.
- R7: A change of `chan_en` during a ramp reverses the direction from the current code, without jumping to an end point. The 64-edge dwell restarts at the edge that sees the change.
- R8: `supply_ok` low forces `sw_en` and `pwr_good` to 0 in the same cycle, and `ref_code` is 0 after the next edge. While `supply_ok` is low, `chan_en` has no effect.
- R9: `global_on` low forces `sw_en` and `pwr_good` to 0 in the same cycle, and `ref_code` is 0 after the next edge.
- R10: `ramping` is 1 exactly when `sw_en` is 1 and `pwr_good` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply lockout cleared (1 = supply above threshold) |
| global_on | input | 1 | Global on/off control (0 = all channels off) |
| chan_en | input | 1 | Channel enable (1 = ramp up, 0 = ramp down) |
| ref_code | output | 6 | Reference step code, 0 to 63 |
| sw_en | output | 1 | Power switch enable |
| ramping | output | 1 | Ramp in progress |
| pwr_good | output | 1 | Output regulated at full reference |

## Verification
The assertions assume that `supply_ok`, `global_on` and `chan_en` are synchronous to `clk` and stable around each rising edge. The single-step and full-code properties only apply in cycles where both the supply flag and the global switch are high. The bench changes every input on the falling edge. Its random segments hold each input combination for 1 to 400 cycles. Within them the supply and global inputs drop rarely, so that long ramps, reversals and both shutdown paths all occur.

// File: rtl/reframp_seq.sv
module reframp_seq #(
  parameter int CODE_W = 6,
  parameter int DWELL  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              global_on,
  input  logic              chan_en,
  output logic [CODE_W-1:0] ref_code,
  output logic              sw_en,
  output logic              ramping,
  output logic              pwr_good
);
  localparam int TICK_W = (DWELL > 2) ? $clog2(DWELL) : 1;
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(DWELL - 1);

  logic [CODE_W-1:0] code_q;
  logic [TICK_W-1:0] tick_q;
  logic              on_q, pg_q, dir_q;

  wire live      = supply_ok & global_on;
  wire tick_wrap = (tick_q == TICK_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      tick_q <= '0;
      on_q   <= 1'b0;
      pg_q   <= 1'b0;
      dir_q  <= 1'b0;
    end else if (!live) begin
      code_q <= '0;
      tick_q <= '0;
      on_q   <= 1'b0;
      pg_q   <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      dir_q <= chan_en;
      if (chan_en != dir_q) begin
        tick_q <= '0;
        if (chan_en) on_q <= 1'b1;
        else         pg_q <= 1'b0;
      end else if (on_q) begin
        if (chan_en) begin
          if (!pg_q) begin
            if (tick_wrap) begin
              tick_q <= '0;
              if (code_q == TOP) pg_q <= 1'b1;
              else               code_q <= code_q + 1'b1;
            end else begin
              tick_q <= tick_q + 1'b1;
            end
          end
        end else begin
          if (tick_wrap) begin
            tick_q <= '0;
            if (code_q == '0) on_q <= 1'b0;
            else              code_q <= code_q - 1'b1;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
      end
    end
  end

  assign ref_code = code_q;
  assign sw_en    = on_q & live;
  assign pwr_good = pg_q & chan_en & live;
  assign ramping  = sw_en & ~pwr_good;
endmodule

// File: rtl/reframp_seq_chk.sv
module reframp_seq_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_ok,
  input logic              global_on,
  input logic              chan_en,
  input logic [CODE_W-1:0] ref_code,
  input logic              sw_en,
  input logic              ramping,
  input logic              pwr_good
);
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && global_on) |=> (ref_code == $past(ref_code) ||
                                  ref_code == $past(ref_code) + 1'b1 ||
                                  ref_code == $past(ref_code) - 1'b1));

  assert_pg_at_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> (ref_code == {CODE_W{1'b1}}));

  assert_pg_drop_on_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !pwr_good);

  assert_supply_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (!sw_en && !pwr_good && !ramping));

  assert_global_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !global_on |-> (!sw_en && !pwr_good));

  assert_code_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(supply_ok && global_on) |=> (ref_code == '0));
endmodule

bind reframp_seq reframp_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .global_on(global_on),
  .chan_en(chan_en), .ref_code(ref_code), .sw_en(sw_en), .ramping(ramping),
  .pwr_good(pwr_good)
);

// File: tb/reframp_seq_test.sv
module reframp_seq_test;
  localparam int CLK_P = 10;
  localparam int DW    = 64;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       supply_ok = 1'b0, global_on = 1'b0, chan_en = 1'b0;
  logic [5:0] ref_code;
  logic       sw_en, ramping, pwr_good;

  int checks = 0, fails = 0;

  reframp_seq uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .global_on(global_on),
    .chan_en(chan_en), .ref_code(ref_code), .sw_en(sw_en), .ramping(ramping),
    .pwr_good(pwr_good)
  );

  always #(CLK_P/2) clk = ~clk;

  // bench model of the required behaviour
  logic [5:0] m_code;
  int         m_tick;
  logic       m_on, m_pg, m_dir;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !(supply_ok && global_on)) begin
      m_code <= 0; m_tick <= 0; m_on <= 0; m_pg <= 0; m_dir <= 0;
    end else begin
      m_dir <= chan_en;
      if (chan_en != m_dir) begin
        m_tick <= 0;
        if (chan_en) m_on <= 1; else m_pg <= 0;
      end else if (m_on && !(chan_en && m_pg)) begin
        if (m_tick == DW-1) begin
          m_tick <= 0;
          if (chan_en) begin
            if (m_code == 63) m_pg <= 1; else m_code <= m_code + 1;
          end else begin
            if (m_code == 0) m_on <= 0; else m_code <= m_code - 1;
          end
        end else m_tick <= m_tick + 1;
      end
    end
  end

  function automatic logic exp_sw();
    return m_on && supply_ok && global_on;
  endfunction
  function automatic logic exp_pg();
    return m_pg && chan_en && supply_ok && global_on;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    cyc(3);
    chk("R1 code", ref_code, 0); chk("R1 sw_en", sw_en, 0);
    chk("R1 ramping", ramping, 0); chk("R1 pwr_good", pwr_good, 0);
    rst_n = 1'b1;
    supply_ok = 1'b1; global_on = 1'b1;
    cyc(5);
    chk("R1 idle sw_en", sw_en, 0);

    // full ramp up
    chan_en = 1'b1;
    cyc(1);
    chk("R2 sw_en", sw_en, 1); chk("R2 code", ref_code, 0);
    chk("R10 ramping", ramping, 1);
    cyc(63); chk("R3 hold at 0", ref_code, 0);
    cyc(1);  chk("R3 code 1", ref_code, 1);
    cyc(64); chk("R3 code 2", ref_code, 2);
    cyc(4096 - 129); chk("R4 code 63", ref_code, 63); chk("R4 pg low", pwr_good, 0);
    cyc(1); chk("R4 pg high", pwr_good, 1); chk("R10 ramping off", ramping, 0);

    // full ramp down
    chan_en = 1'b0; #1;
    chk("R5 pg drop", pwr_good, 0);
    cyc(64); chk("R5 hold 63", ref_code, 63);
    cyc(1);  chk("R5 code 62", ref_code, 62);
    cyc(63*64 - 65); chk("R6 code 1", ref_code, 1);
    cyc(1); chk("R6 code 0", ref_code, 0); chk("R6 sw_en on", sw_en, 1);
    cyc(4096 - 63*64 - 1); chk("R6 sw_en last", sw_en, 1);
    cyc(1); chk("R6 sw_en off", sw_en, 0);

    // reversal in mid-ramp
    chan_en = 1'b1;
    cyc(641); chk("R7 code 10", ref_code, 10);
    chan_en = 1'b0;
    cyc(64); chk("R7 hold 10", ref_code, 10);
    cyc(1);  chk("R7 code 9", ref_code, 9);
    chan_en = 1'b1;
    cyc(65); chk("R7 back to 10", ref_code, 10);

    // supply loss
    cyc(200);
    supply_ok = 1'b0; #1;
    chk("R8 sw_en cut", sw_en, 0); chk("R8 ramping cut", ramping, 0);
    cyc(1); chk("R8 code 0", ref_code, 0);
    cyc(200); chk("R8 en ignored sw", sw_en, 0); chk("R8 en ignored code", ref_code, 0);
    supply_ok = 1'b1;
    cyc(1); chk("R2 restart", sw_en, 1);

    // global off at full scale
    cyc(4096); chk("R4 pg again", pwr_good, 1);
    global_on = 1'b0; #1;
    chk("R9 sw_en cut", sw_en, 0); chk("R9 pg cut", pwr_good, 0);
    cyc(1); chk("R9 code 0", ref_code, 0);
    global_on = 1'b1;
    cyc(2);

    // random segments compared against the model
    for (int s = 0; s < 150; s++) begin
      int len = $urandom_range(1, 400);
      supply_ok = ($urandom_range(0, 99) < 92);
      global_on = ($urandom_range(0, 99) < 95);
      chan_en   = ($urandom_range(0, 99) < 55);
      for (int k = 0; k < len; k++) begin
        #1;
        chk("R3 R7 model code", ref_code, m_code);
        chk("R8 R9 model sw_en", sw_en, exp_sw());
        chk("R4 R5 model pwr_good", pwr_good, exp_pg());
        chk("R10 model ramping", ramping, exp_sw() && !exp_pg());
        cyc(1);
      end
    end
    finish_run();
  end
endmodule